// File: doc/BRIEF.md
# Synchronous Two-Digit Seconds Counter

This block counts seconds from 00 to 59 as two BCD digits, a units digit and a tens digit. One shared clock drives every flip-flop. A one-cycle `tick` input marks each second. Each digit is a 4-bit synchronous counter slice. A slice has two count enables, a synchronous clear and a ripple-carry output. The units slice's ripple carry feeds the tens slice's enable. No slice ever takes its clock from decoded counter bits, so a glitch while bits change cannot cause a false count.

Each slice runs a small mode machine that is evaluated on every edge:

- `MD_CLEAR`: the clear input is high, and the slice loads 0.
- `MD_WRAP`: both enables are high and the slice is at its last value, and it loads 0.
- `MD_STEP`: both enables are high and the slice is below its last value, and it adds 1.
- `MD_IDLE`: any other case, and the slice holds its value.

The transitions run from `MD_IDLE` to `MD_STEP` or `MD_WRAP` when the enables rise, and from any mode to `MD_CLEAR` while the hold-clear input is high. The last value is detected by comparing all four bits.

A level-sensitive `hold_clr` input, normally driven by a switch, forces 00 and keeps the count there. A registered `min_wrap` pulse marks the roll from 59 back to 00. Each digit also drives a decoder that produces an active-low seven-segment pattern.

Top module: `sec_counter`

## Requirements
- R1: While `hold_clr` is high at a clock edge, both digits are 0 after that edge and remain 0 for as long as it stays high.
- R2: With `hold_clr` low and `tick` low at an edge, neither digit changes.
- R3: With `tick` high and units below 9, units increases by 1 at the edge and tens is unchanged.
- R4: Units counts 7 to 8 to 9 without skipping. A carry happens only when units equals 9 (all four bits 1001). In that case units becomes 0 and tens increases by 1 at the same edge.
- R5: At count 59 with `tick` high, both digits become 0 at the next edge.
- R6: `min_wrap` is high for exactly the one cycle that follows the 59-to-00 edge, and it is low at all other times.
- R7: `hold_clr` takes priority over `tick`: with both high, the count goes to 00 and `min_wrap` stays low.
- R8: Each segment output is active low, with bit 6 = a through bit 0 = g. The patterns for digits 0 to 9 are the standard ones, for example 0 = 0000001 and 8 = 0000000.
- R9: Units never exceeds 9 and tens never exceeds 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for all stages |
| tick | input | 1 | One-cycle count request, once per second |
| hold_clr | input | 1 | Synchronous clear; holds 00 while high |
| units | output | 4 | Units BCD digit |
| tens | output | 4 | Tens BCD digit |
| min_wrap | output | 1 | One-cycle pulse after the 59-to-00 roll |
| seg_units_n | output | 7 | Active-low segments a..g for units |
| seg_tens_n | output | 7 | Active-low segments a..g for tens |

## Verification
The bench builds the block with its default parameters: a digit width of 4, a units last value of 9 and a tens last value of 5. These values place the full-decode carry at 9, the 7-to-8 step that the carry must not react to, and the 59-to-00 roll within about sixty ticks. The bench runs more than seventy ticks in a row, which crosses the wrap. It then interleaves idle cycles and applies `hold_clr` in the middle of a count, including cycles where `tick` is also high.

// File: rtl/sec_pkg.sv
package sec_pkg;
    localparam int SEG_W = 7;
    typedef logic [SEG_W-1:0] seg_t;
    typedef enum logic [1:0] {
        MD_IDLE,
        MD_STEP,
        MD_WRAP,
        MD_CLEAR
    } slice_mode_t;
endpackage

// File: rtl/bcd_slice.sv
module bcd_slice
    import sec_pkg::*;
#(
    parameter int W    = 4,
    parameter int LAST = 9
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         ena_p,
    input  logic         ena_t,
    output logic [W-1:0] q,
    output logic         rco
);
    localparam logic [W-1:0] LAST_V = W'(LAST);

    slice_mode_t mode;
    logic        at_last;

    assign at_last = (q == LAST_V);
    assign rco     = at_last && ena_t;

    always_comb begin
        if (clr)                  mode = MD_CLEAR;
        else if (ena_p && ena_t)  mode = at_last ? MD_WRAP : MD_STEP;
        else                      mode = MD_IDLE;
    end

    always_ff @(posedge clk) begin
        unique case (mode)
            MD_CLEAR: q <= '0;
            MD_WRAP:  q <= '0;
            MD_STEP:  q <= q + 1'b1;
            MD_IDLE:  q <= q;
        endcase
    end

    assert_clear_R1: assert property (@(posedge clk) clr |=> q == '0);
    assert_idle_R2: assert property (@(posedge clk) disable iff (clr)
        !(ena_p && ena_t) |=> $stable(q));
    assert_step_R3: assert property (@(posedge clk) disable iff (clr)
        (ena_p && ena_t && q != LAST_V) |=> q == W'($past(q) + 1'b1));
    assert_wrap_R5: assert property (@(posedge clk) disable iff (clr)
        (ena_p && ena_t && q == LAST_V) |=> q == '0);
    assert_range_R9: assert property (@(posedge clk) disable iff (clr)
        q <= LAST_V);
endmodule

// File: rtl/seg7_decode.sv
module seg7_decode
    import sec_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] digit,
    output seg_t         seg_n
);
    seg_t on;

    always_comb begin
        case (int'(digit))
            0:       on = 7'b1111110;
            1:       on = 7'b0110000;
            2:       on = 7'b1101101;
            3:       on = 7'b1111001;
            4:       on = 7'b0110011;
            5:       on = 7'b1011011;
            6:       on = 7'b1011111;
            7:       on = 7'b1110000;
            8:       on = 7'b1111111;
            9:       on = 7'b1111011;
            default: on = 7'b0000000;
        endcase
        seg_n = ~on;
    end
endmodule

// File: rtl/sec_counter.sv
module sec_counter
    import sec_pkg::*;
#(
    parameter int W          = 4,
    parameter int UNITS_LAST = 9,
    parameter int TENS_LAST  = 5
) (
    input  logic         clk,
    input  logic         tick,
    input  logic         hold_clr,
    output logic [W-1:0] units,
    output logic [W-1:0] tens,
    output logic         min_wrap,
    output logic [6:0]   seg_units_n,
    output logic [6:0]   seg_tens_n
);
    logic units_rco;
    logic tens_rco;

    bcd_slice #(.W(W), .LAST(UNITS_LAST)) u_units (
        .clk(clk), .clr(hold_clr), .ena_p(1'b1), .ena_t(tick),
        .q(units), .rco(units_rco)
    );

    bcd_slice #(.W(W), .LAST(TENS_LAST)) u_tens (
        .clk(clk), .clr(hold_clr), .ena_p(tick), .ena_t(units_rco),
        .q(tens), .rco(tens_rco)
    );

    always_ff @(posedge clk) begin
        if (hold_clr) min_wrap <= 1'b0;
        else          min_wrap <= tens_rco;
    end

    seg7_decode #(.W(W)) u_seg_units (.digit(units), .seg_n(seg_units_n));
    seg7_decode #(.W(W)) u_seg_tens  (.digit(tens),  .seg_n(seg_tens_n));

    assert_carry_R4: assert property (@(posedge clk) disable iff (hold_clr)
        (tick && units == W'(UNITS_LAST) && tens != W'(TENS_LAST))
        |=> units == '0 && tens == W'($past(tens) + 1'b1));
    assert_nocarry_R4: assert property (@(posedge clk) disable iff (hold_clr)
        (units != W'(UNITS_LAST)) |=> $stable(tens));
    assert_wrap_pulse_R6: assert property (@(posedge clk) disable iff (hold_clr)
        min_wrap |-> (units == '0 && tens == '0));
    assert_priority_R7: assert property (@(posedge clk)
        hold_clr |=> (!min_wrap && units == '0 && tens == '0));
endmodule

// File: tb/tb_sec_counter.sv
module tb_sec_counter;
    logic       clk = 1'b0;
    logic       tick = 1'b0;
    logic       hold_clr = 1'b1;
    logic [3:0] units, tens;
    logic       min_wrap;
    logic [6:0] seg_units_n, seg_tens_n;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        int    u;
        int    t;
        bit    w;
        string tag;
    } exp_t;
    exp_t q[$];

    int mu = 0, mt = 0;

    always #4 clk = ~clk;

    sec_counter dut (
        .clk(clk), .tick(tick), .hold_clr(hold_clr),
        .units(units), .tens(tens), .min_wrap(min_wrap),
        .seg_units_n(seg_units_n), .seg_tens_n(seg_tens_n)
    );

    function automatic logic [6:0] seg_ref(int d);
        case (d)
            0: return ~7'h7E;  1: return ~7'h30;  2: return ~7'h6D;
            3: return ~7'h79;  4: return ~7'h33;  5: return ~7'h5B;
            6: return ~7'h5F;  7: return ~7'h70;  8: return ~7'h7F;
            9: return ~7'h7B;  default: return 7'h7F;
        endcase
    endfunction

    task automatic drive(input bit tk, input bit hc);
        exp_t e;
        @(negedge clk);
        tick = tk;
        hold_clr = hc;
        e.w = 0;
        if (hc) begin
            e.tag = tk ? "R7" : "R1";
            mu = 0; mt = 0;
        end else if (!tk) begin
            e.tag = "R2";
        end else if (mu == 9) begin
            if (mt == 5) begin
                e.tag = "R5"; mt = 0; e.w = 1;
            end else begin
                e.tag = "R4"; mt = mt + 1;
            end
            mu = 0;
        end else begin
            e.tag = (mu == 7) ? "R4" : "R3";
            mu = mu + 1;
        end
        e.u = mu; e.t = mt;
        q.push_back(e);
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(units == 4'(e.u), e.tag, "units", int'(units), e.u);
                chk(tens == 4'(e.t), e.tag, "tens", int'(tens), e.t);
                chk(min_wrap == e.w, (e.w || e.tag == "R7") ? e.tag : "R6",
                    "min_wrap", int'(min_wrap), int'(e.w));
                chk(seg_units_n == seg_ref(e.u), "R8", "seg_units",
                    int'(seg_units_n), int'(seg_ref(e.u)));
                chk(seg_tens_n == seg_ref(e.t), "R8", "seg_tens",
                    int'(seg_tens_n), int'(seg_ref(e.t)));
                chk(units <= 4'd9 && tens <= 4'd5, "R9", "range",
                    int'(units) * 16 + int'(tens), 0);
            end
        end
    end

    initial begin
        repeat (3) drive(0, 1);
        for (int i = 0; i < 75; i++) drive(1, 0);
        for (int i = 0; i < 30; i++) drive(i % 3 == 0, 0);
        drive(1, 1);
        drive(1, 1);
        drive(0, 1);
        for (int i = 0; i < 12; i++) drive(1, 0);
        drive(1, 1);
        for (int i = 0; i < 64; i++) drive(1, 0);
        drive(0, 0);
        drive(0, 0);
        repeat (3) @(negedge clk);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule